// File: doc/BRIEF.md
# Program Memory Pointer Access Unit

This unit performs pointer-based access to a program memory that is organised in 16-bit words. A 16-bit byte pointer is formed from two 8-bit registers of a register pair. A load command fetches the word that the pointer selects and returns one byte of it. A store command writes a whole 16-bit word at the pointer's word address. Either command may optionally advance the pointer afterwards and write the new value back into the register pair.

The pointer is a byte address, but the memory holds words. Bits 15..1 of the pointer form the word address. Bit 0 chooses the byte half for a load. For a store, bit 0 is expected to be clear. A load with increment advances the pointer by one. A store with increment advances it by two. The access always uses the pointer value from before the increment.

A command is accepted only while the unit is idle. The memory port is synchronous with one clock of read latency. A done strobe marks the cycle in which the byte result and the pointer writeback are valid.

Top module: `pmem_ptr_unit`

## Requirements
- R1: The pointer is {ptr_hi_in, ptr_lo_in}, captured when a command is accepted. During the access cycle, mem_addr equals pointer bits 15..1 and mem_en is 1.
- R2: For a load (cmd_op bit 1 = 0), byte_out in the done cycle is bits 7:0 of the addressed word when pointer bit 0 is 0, and bits 15:8 when it is 1. byte_out is 0 whenever done is 0.
- R3: A load with increment (cmd_op = 2'b01) writes pointer+1 back to the pair in the done cycle: ptr_we = 1, ptr_hi_out = upper byte, ptr_lo_out = lower byte. A plain load (2'b00) or a plain store (2'b10) never raises ptr_we.
- R4: A store (cmd_op bit 1 = 1) drives mem_we = 1 and mem_wdata = store_data in the access cycle. It writes the word at pointer bits 15..1.
- R5: A store with increment (cmd_op = 2'b11) writes pointer+2 back to the pair in the done cycle.
- R6: The memory address used by an incrementing command is taken from the pointer before it is incremented.
- R7: The incremented pointer wraps modulo 2^16. A load with increment from 0xFFFF gives 0x0000. A store with increment from 0xFFFE gives 0x0000.
- R8: A store with pointer bit 0 set uses bits 15..1 as the address, ignoring bit 0. It raises misalign for exactly the done cycle. An incrementing store still writes back pointer+2.
- R9: If cmd_valid is seen while idle at clock edge k, mem_en is 1 in the cycle after edge k. done is 1 in the cycle after edge k+1, and busy returns to 0 after edge k+2.
- R10: cmd_valid is ignored while busy. No second access starts and memory is not written.
- R11: After reset, busy, done, mem_en, mem_we, ptr_we and misalign are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Bit 1: store (1) or load (0). Bit 0: post-increment |
| store_data | input | 16 | Word to store |
| ptr_lo_in | input | 8 | Lower pointer register |
| ptr_hi_in | input | 8 | Upper pointer register |
| busy | output | 1 | Command in progress |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one clock after mem_en |
| done | output | 1 | Result and writeback valid |
| byte_out | output | 8 | Loaded byte |
| ptr_we | output | 1 | Register pair writeback enable |
| ptr_lo_out | output | 8 | New lower pointer byte |
| ptr_hi_out | output | 8 | New upper pointer byte |
| misalign | output | 1 | Store issued with pointer bit 0 set |

## Verification
A command driven before clock edge k shows its memory request in the cycle after edge k. Its done strobe, byte, writeback and misalign flag follow in the cycle after edge k+1. The unit is idle again after edge k+2. The bench drives inputs on falling edges and samples each of these three cycles at the falling edge inside it. It compares the samples with values worked out from its own memory model and register-pair model. Writes are confirmed by reading the words back through later load commands.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_RESULT = 2'd2
   } pmu_state_t;

   localparam int OP_STORE_BIT = 1;
   localparam int OP_INC_BIT   = 0;
endpackage

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
   import pmu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   output logic accept,
   output logic in_access,
   output logic in_result,
   output logic busy
);
   pmu_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:   if (cmd_valid) st_d = ST_ACCESS;
         ST_ACCESS: st_d = ST_RESULT;
         ST_RESULT: st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign accept    = (st_q == ST_IDLE) && cmd_valid;
   assign in_access = (st_q == ST_ACCESS);
   assign in_result = (st_q == ST_RESULT);
   assign busy      = (st_q != ST_IDLE);

   // R9
   access_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> in_access);
   // R9
   result_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_access |=> in_result);
endmodule

// File: rtl/pmu_ptr_step.sv
module pmu_ptr_step #(
   parameter int PTR_W = 16
) (
   input  logic [PTR_W-1:0] ptr,
   input  logic             word_step,
   output logic [PTR_W-1:0] ptr_next
);
   localparam logic [PTR_W-1:0] STEP_BYTE = PTR_W'(1);
   localparam logic [PTR_W-1:0] STEP_WORD = PTR_W'(2);

   assign ptr_next = ptr + (word_step ? STEP_WORD : STEP_BYTE);
endmodule

// File: rtl/pmu_lane_sel.sv
module pmu_lane_sel #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 2,
   localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [BYTE_W*LANES-1:0] word,
   input  logic [SEL_W-1:0]        sel,
   output logic [BYTE_W-1:0]       byte_sel
);
   logic [BYTE_W-1:0] lane [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = word[g*BYTE_W +: BYTE_W];
   end

   assign byte_sel = lane[sel];
endmodule

// File: rtl/pmem_ptr_unit.sv
module pmem_ptr_unit
   import pmu_pkg::*;
#(
   parameter int REG_W  = 8,
   parameter int WORD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [1:0]          cmd_op,
   input  logic [WORD_W-1:0]   store_data,
   input  logic [REG_W-1:0]    ptr_lo_in,
   input  logic [REG_W-1:0]    ptr_hi_in,
   output logic                busy,
   output logic                mem_en,
   output logic                mem_we,
   output logic [2*REG_W-2:0]  mem_addr,
   output logic [WORD_W-1:0]   mem_wdata,
   input  logic [WORD_W-1:0]   mem_rdata,
   output logic                done,
   output logic [REG_W-1:0]    byte_out,
   output logic                ptr_we,
   output logic [REG_W-1:0]    ptr_lo_out,
   output logic [REG_W-1:0]    ptr_hi_out,
   output logic                misalign
);
   localparam int PTR_W = 2 * REG_W;
   localparam int LANES = WORD_W / REG_W;

   if (LANES != 2) begin : g_bad_geom
      $error("pmem_ptr_unit: WORD_W must be twice REG_W");
   end
   if (REG_W < 2) begin : g_bad_reg
      $error("pmem_ptr_unit: REG_W too small");
   end

   logic             accept, in_access, in_result;
   logic [PTR_W-1:0] ptr_q, ptr_next;
   logic [WORD_W-1:0] wdata_q;
   logic             is_store_q, is_inc_q;
   logic [REG_W-1:0] lane_byte;

   pmu_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .accept    (accept),
      .in_access (in_access),
      .in_result (in_result),
      .busy      (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q      <= '0;
         wdata_q    <= '0;
         is_store_q <= 1'b0;
         is_inc_q   <= 1'b0;
      end else if (accept) begin
         ptr_q      <= {ptr_hi_in, ptr_lo_in};
         wdata_q    <= store_data;
         is_store_q <= cmd_op[OP_STORE_BIT];
         is_inc_q   <= cmd_op[OP_INC_BIT];
      end
   end

   pmu_ptr_step #(.PTR_W(PTR_W)) u_step (
      .ptr       (ptr_q),
      .word_step (is_store_q),
      .ptr_next  (ptr_next)
   );

   pmu_lane_sel #(.BYTE_W(REG_W), .LANES(LANES)) u_sel (
      .word     (mem_rdata),
      .sel      (ptr_q[0]),
      .byte_sel (lane_byte)
   );

   assign mem_en     = in_access;
   assign mem_we     = in_access && is_store_q;
   assign mem_addr   = ptr_q[PTR_W-1:1];
   assign mem_wdata  = wdata_q;
   assign done       = in_result;
   assign byte_out   = (in_result && !is_store_q) ? lane_byte : '0;
   assign ptr_we     = in_result && is_inc_q;
   assign ptr_lo_out = ptr_next[REG_W-1:0];
   assign ptr_hi_out = ptr_next[PTR_W-1:REG_W];
   assign misalign   = in_result && is_store_q && ptr_q[0];

   // R9
   done_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |=> (done && $stable(mem_addr)));
   // R4
   we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en);
   // R8
   misalign_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |=> !misalign);
   // R10
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_en, done}));
   // R3
   wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we |-> done);
   // R6
   wb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_we && $past(mem_en)) |->
         (({ptr_hi_out, ptr_lo_out} - {$past(mem_addr), ptr_q[0]}) == (misalign || $past(mem_we) ? PTR_W'(2) : PTR_W'(1))));
endmodule

// File: tb/pmem_ptr_unit_test.sv
module pmem_ptr_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'b00;
   logic [15:0] store_data = '0;
   logic [7:0]  r30 = '0, r31 = '0;
   logic        busy, mem_en, mem_we, done, ptr_we, misalign;
   logic [14:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic [7:0]  byte_out, ptr_lo_out, ptr_hi_out;

   logic [15:0] mem [256];

   int checks = 0;
   int fails  = 0;

   // sampled per command
   logic        s_en, s_we, s_done1, s_done2, s_wb, s_mis, s_mis_next, s_busy3, s_en3;
   logic [14:0] s_addr;
   logic [15:0] s_wdata;
   logic [7:0]  s_byte, s_byte1;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmem_ptr_unit uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .store_data(store_data), .ptr_lo_in(r30), .ptr_hi_in(r31),
      .busy(busy), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
      .byte_out(byte_out), .ptr_we(ptr_we), .ptr_lo_out(ptr_lo_out),
      .ptr_hi_out(ptr_hi_out), .misalign(misalign)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         mem_rdata <= mem[mem_addr[7:0]];
      end
      if (ptr_we) begin
         r30 <= ptr_lo_out;
         r31 <= ptr_hi_out;
      end
   end

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] op, input logic [15:0] ptr, input logic [15:0] data,
                      input logic hold);
      @(negedge clk);
      {r31, r30} = ptr;
      cmd_op = op; store_data = data; cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      s_en = mem_en; s_we = mem_we; s_addr = mem_addr; s_wdata = mem_wdata;
      s_done1 = done; s_byte1 = byte_out;
      if (hold) begin
         cmd_op = 2'b10; store_data = 16'hDEAD;
      end else cmd_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      s_done2 = done; s_byte = byte_out; s_wb = ptr_we; s_mis = misalign;
      cmd_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      s_mis_next = misalign; s_busy3 = busy; s_en3 = mem_en;
   endtask

   task automatic common(input string req, input logic [15:0] ptr, input logic st);
      chk(s_en == 1'b1, {req, " R1 mem_en in access"}, s_en, 1);
      chk(s_addr == ptr[15:1], {req, " R1 R6 mem_addr"}, s_addr, ptr[15:1]);
      chk(s_we == st, {req, " R4 mem_we"}, s_we, st);
      chk(s_done1 == 1'b0 && s_done2 == 1'b1, {req, " R9 done timing"}, {s_done1, s_done2}, 2'b01);
      chk(s_busy3 == 1'b0, {req, " R9 idle after done"}, s_busy3, 0);
   endtask

   task automatic t_reset;
      chk({busy, done, mem_en, mem_we, ptr_we, misalign} == '0, "R11 reset outputs",
          {busy, done, mem_en, mem_we, ptr_we, misalign}, 0);
   endtask

   task automatic t_load_bytes;
      run(2'b00, 16'h0024, '0, 1'b0);
      common("R2 low", 16'h0024, 1'b0);
      chk(s_byte == 8'hC3, "R2 low byte", s_byte, 8'hC3);
      chk(s_byte1 == 8'h00, "R2 byte_out zero outside done", s_byte1, 0);
      chk(s_wb == 1'b0 && {r31, r30} == 16'h0024, "R3 plain load no writeback", {r31, r30}, 16'h0024);
      run(2'b00, 16'h0025, '0, 1'b0);
      chk(s_byte == 8'hA5, "R2 high byte", s_byte, 8'hA5);
   endtask

   task automatic t_load_inc;
      run(2'b01, 16'h0025, '0, 1'b0);
      common("R3", 16'h0025, 1'b0);
      chk(s_byte == 8'hA5, "R6 load inc uses old pointer", s_byte, 8'hA5);
      chk(s_wb == 1'b1 && {r31, r30} == 16'h0026, "R3 load inc writeback", {r31, r30}, 16'h0026);
      run(2'b01, 16'h01FF, '0, 1'b0);
      chk({r31, r30} == 16'h0200, "R3 carry into upper register", {r31, r30}, 16'h0200);
   endtask

   task automatic t_store;
      run(2'b10, 16'h0040, 16'hBEEF, 1'b0);
      common("R4", 16'h0040, 1'b1);
      chk(s_wdata == 16'hBEEF, "R4 mem_wdata", s_wdata, 16'hBEEF);
      chk(s_wb == 1'b0 && {r31, r30} == 16'h0040, "R3 plain store no writeback", {r31, r30}, 16'h0040);
      run(2'b00, 16'h0041, '0, 1'b0);
      chk(s_byte == 8'hBE, "R4 stored high byte", s_byte, 8'hBE);
      run(2'b00, 16'h0040, '0, 1'b0);
      chk(s_byte == 8'hEF, "R4 stored low byte", s_byte, 8'hEF);
   endtask

   task automatic t_store_inc;
      run(2'b11, 16'h0042, 16'h1357, 1'b0);
      common("R5", 16'h0042, 1'b1);
      chk(s_wb == 1'b1 && {r31, r30} == 16'h0044, "R5 store inc writeback", {r31, r30}, 16'h0044);
      chk(s_mis == 1'b0, "R8 aligned store no flag", s_mis, 0);
      chk(mem[8'h21] == 16'h1357, "R5 word written at old pointer", mem[8'h21], 16'h1357);
   endtask

   task automatic t_wrap;
      run(2'b01, 16'hFFFF, '0, 1'b0);
      chk(s_addr == 15'h7FFF, "R7 wrap load addr", s_addr, 15'h7FFF);
      chk(s_byte == 8'h12, "R7 wrap load byte", s_byte, 8'h12);
      chk({r31, r30} == 16'h0000, "R7 load wrap to zero", {r31, r30}, 0);
      run(2'b11, 16'hFFFE, 16'h4242, 1'b0);
      chk({r31, r30} == 16'h0000, "R7 store wrap to zero", {r31, r30}, 0);
   endtask

   task automatic t_misalign;
      run(2'b11, 16'h0051, 16'h7788, 1'b0);
      chk(s_addr == 15'h0028 && s_we, "R8 odd store address", s_addr, 15'h0028);
      chk(s_mis == 1'b1, "R8 misalign in done", s_mis, 1);
      chk(s_mis_next == 1'b0, "R8 misalign one cycle", s_mis_next, 0);
      chk({r31, r30} == 16'h0053, "R8 odd store inc by two", {r31, r30}, 16'h0053);
      chk(mem[8'h28] == 16'h7788, "R8 word written", mem[8'h28], 16'h7788);
   endtask

   task automatic t_busy_ignore;
      mem[8'h30] = 16'h0F0F;
      run(2'b00, 16'h0060, '0, 1'b1);
      chk(s_en3 == 1'b0 && s_busy3 == 1'b0, "R10 no second access", {s_en3, s_busy3}, 0);
      chk(mem[8'h30] == 16'h0F0F, "R10 memory untouched", mem[8'h30], 16'h0F0F);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101);
      mem[8'h12] = 16'hA5C3;
      mem[8'hFF] = 16'h1234;
      #(CLK_PERIOD * 2 + 1);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_load_bytes();
      t_load_inc();
      t_store();
      t_store_inc();
      t_wrap();
      t_misalign();
      t_busy_ignore();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule